// File: doc/BRIEF.md
# Pipelined Burst SRAM with Byte Writes

This block models a synchronous pipelined SRAM with byte-lane writes and a short wrapping burst. Every control input is captured on the rising clock edge. Read data passes through a RAM stage and then an output register, so a word appears on the data-out port one clock after the edge at which its address was taken.

An access starts on either of two active-low address strobes. The processor-side strobe always begins with a read. A write it starts completes on the following edge. The controller-side strobe can read or write in the same edge that takes the address.

Between strobes, an advance input steps a two-bit wrapping counter through the burst. The counter follows either a linear order or an exclusive-OR (interleaved) order. The shared bidirectional data bus is represented by a registered data-out word and a separate drive-enable output. That drive enable is switched off on deselection, on the first cycle after leaving the deselected state, and whenever a write is seen.

Top module: `sbs_sram_top`

## Requirements
- R1: A read whose address is sampled at edge k presents that word on `rdata_o` after edge k+1, with `drive_o` high when `oe_n_i` is low. Back-to-back reads deliver one word per clock.
- R2: The part is selected when `ce1_n_i`=0, `ce2_i`=1 and `ce3_n_i`=0. A recognised strobe taken while the part is not selected deselects it, and `drive_o` is low after that edge. Write inputs given while deselected and with no strobe change nothing.
- R3: While `ce1_n_i` is high, `adsp_n_i` has no effect. With `adsc_n_i` high the access in progress carries on. With `adsc_n_i` low the controller strobe decides what happens.
- R4: A start on `adsp_n_i` is always a read: write inputs and `adv_n_i` are ignored at that edge. The write happens on the next edge, at the same address when `adv_n_i` is high, using the write inputs sampled at that edge.
- R5: A start on `adsc_n_i` while the processor strobe is not in effect writes in the same edge when `gw_n_i` or `bwe_n_i` is low. In that edge `adv_n_i` is ignored and the word goes to exactly `addr_i`.
- R6: `gw_n_i` low writes all four byte lanes regardless of the other write inputs. Otherwise, `bwe_n_i` low writes byte lane b (bits 8b+7:8b) exactly when `bw_n_i[b]` is low, and every other lane keeps its value. A read takes place only when both `gw_n_i` and `bwe_n_i` are high.
- R7: On the first cycle of an access that follows the deselected state, `drive_o` is low whatever `oe_n_i` is.
- R8: `drive_o` is low whenever `oe_n_i` is high, or `gw_n_i` or `bwe_n_i` is low (this follows the inputs without a clock). It is also low for the cycle after any write edge.
- R9: With both strobes high while selected, `adv_n_i` low advances the burst step n (modulo 4) and `adv_n_i` high repeats the current address. The low two address bits are (base+n) mod 4 when `lin_i` was 1 at the start edge, and base XOR n when it was 0. The burst keeps the upper address bits.
- R10: Synchronous reset leaves the part deselected with `drive_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | AW | Word address |
| adsp_n_i | input | 1 | Processor address strobe, active low |
| adsc_n_i | input | 1 | Controller address strobe, active low |
| adv_n_i | input | 1 | Burst advance, active low |
| ce1_n_i | input | 1 | Chip enable, active low; also gates the processor strobe |
| ce2_i | input | 1 | Chip enable, active high |
| ce3_n_i | input | 1 | Chip enable, active low |
| gw_n_i | input | 1 | Global write, active low |
| bwe_n_i | input | 1 | Byte write enable, active low |
| bw_n_i | input | NB | Per-lane byte select, active low |
| oe_n_i | input | 1 | Output enable, active low, not clocked |
| lin_i | input | 1 | Burst order: 1 linear, 0 interleaved; sampled at start |
| wdata_i | input | NB*8 | Write data |
| rdata_o | output | NB*8 | Registered read data |
| drive_o | output | 1 | Data bus drive enable |

## Verification
The bench writes every location of a 16-word array and reads each back as one pipelined stream. This catches a design that is a cycle early or late, or that drives stale data on the first cycle after deselection.

It sweeps all sixteen byte-select patterns and compares the results with a merge computed in the bench. A design that writes unselected lanes, or that lets the byte selects override the global write, fails there.

A processor-strobe write is given conflicting controls and data at its first edge. A design that writes too early therefore leaves the wrong bytes. Address-strobe presses made with the first chip enable high show whether the processor strobe was wrongly obeyed, because such a design deselects and drops the drive. Every base address in both burst orders is walked through advance, hold and wrap, with the order pin flipped after the start edge to catch an order that is not latched.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  localparam int unsigned LANE_W = 8;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } sbs_op_e;
endpackage

// File: rtl/sbs_access_ctrl.sv
module sbs_access_ctrl
  import sbs_pkg::*;
#(
  parameter int unsigned NB = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adsp_n_i,
  input  logic          adsc_n_i,
  input  logic          adv_n_i,
  input  logic          ce1_n_i,
  input  logic          ce2_i,
  input  logic          ce3_n_i,
  input  logic          gw_n_i,
  input  logic          bwe_n_i,
  input  logic [NB-1:0] bw_n_i,
  output logic          ld_o,
  output logic          adv_o,
  output logic          desel_o,
  output sbs_op_e       op_o,
  output logic [NB-1:0] be_o,
  output logic          active_o,
  output logic          wr_seen_o
);
  logic sel, p_act, c_act, strobe;
  logic active_q;

  assign sel       = !ce1_n_i && ce2_i && !ce3_n_i;
  assign p_act     = !adsp_n_i && !ce1_n_i;
  assign c_act     = !adsc_n_i && !p_act;
  assign strobe    = p_act || c_act;
  assign wr_seen_o = !gw_n_i || !bwe_n_i;

  genvar b;
  generate
    for (b = 0; b < NB; b++) begin : g_be
      assign be_o[b] = !gw_n_i || (!bwe_n_i && !bw_n_i[b]);
    end
  endgenerate

  always_comb begin
    ld_o    = 1'b0;
    adv_o   = 1'b0;
    desel_o = 1'b0;
    op_o    = OP_IDLE;
    if (strobe) begin
      if (sel) begin
        ld_o = 1'b1;
        op_o = (c_act && wr_seen_o) ? OP_WR : OP_RD;
      end else begin
        desel_o = 1'b1;
      end
    end else if (active_q) begin
      adv_o = !adv_n_i;
      op_o  = wr_seen_o ? OP_WR : OP_RD;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) active_q <= 1'b0;
    else if (strobe) active_q <= sel;
  end

  assign active_o = active_q;

  assert_adsp_gated_R3: assert property (@(posedge clk) disable iff (rst)
    (ce1_n_i && adsc_n_i) |=> (active_q == $past(active_q)));
endmodule

// File: rtl/sbs_burst_seq.sv
module sbs_burst_seq #(
  parameter int unsigned CW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_i,
  input  logic          adv_i,
  input  logic          lin_i,
  input  logic [CW-1:0] base_i,
  output logic [CW-1:0] low_o
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] base_q, cnt_q, cnt_d, base_sel;
  logic          lin_q, lin_sel;

  function automatic logic [CW-1:0] order_f(input logic [CW-1:0] bs,
                                            input logic [CW-1:0] n,
                                            input logic lin);
    return lin ? (bs + n) : (bs ^ n);
  endfunction

  assign cnt_d    = ld_i ? '0 : (adv_i ? cnt_q + ONE : cnt_q);
  assign base_sel = ld_i ? base_i : base_q;
  assign lin_sel  = ld_i ? lin_i : lin_q;
  assign low_o    = order_f(base_sel, cnt_d, lin_sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      cnt_q  <= '0;
      lin_q  <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      if (ld_i) begin
        base_q <= base_i;
        lin_q  <= lin_i;
      end
    end
  end

  assert_step_R9: assert property (@(posedge clk) disable iff (rst)
    (adv_i && !ld_i) |=> (cnt_q == $past(cnt_q) + ONE));
  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!adv_i && !ld_i) |=> ($stable(cnt_q) && $stable(lin_q) && $stable(base_q)));
endmodule

// File: rtl/sbs_lane_ram.sv
module sbs_lane_ram
  import sbs_pkg::*;
#(
  parameter int unsigned AW = 6,
  parameter int unsigned NB = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [AW-1:0]        addr_i,
  input  logic                 rd_en_i,
  input  logic [NB-1:0]        we_i,
  input  logic [NB*LANE_W-1:0] wd_i,
  output logic [NB*LANE_W-1:0] q_o
);
  localparam int unsigned DEPTH = 1 << AW;

  genvar b;
  generate
    for (b = 0; b < NB; b++) begin : g_lane
      logic [LANE_W-1:0] mem [DEPTH];
      logic [LANE_W-1:0] q_q;
      always_ff @(posedge clk) begin
        if (we_i[b]) mem[addr_i] <= wd_i[b*LANE_W +: LANE_W];
        if (rd_en_i) q_q <= mem[addr_i];
      end
      assign q_o[b*LANE_W +: LANE_W] = q_q;
    end
  endgenerate

  assert_rd_wr_excl_R6: assert property (@(posedge clk) disable iff (rst)
    rd_en_i |-> (we_i == '0));
endmodule

// File: rtl/sbs_sram_top.sv
module sbs_sram_top
  import sbs_pkg::*;
#(
  parameter int unsigned AW = 6,
  parameter int unsigned NB = 4,
  parameter int unsigned CW = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [AW-1:0]        addr_i,
  input  logic                 adsp_n_i,
  input  logic                 adsc_n_i,
  input  logic                 adv_n_i,
  input  logic                 ce1_n_i,
  input  logic                 ce2_i,
  input  logic                 ce3_n_i,
  input  logic                 gw_n_i,
  input  logic                 bwe_n_i,
  input  logic [NB-1:0]        bw_n_i,
  input  logic                 oe_n_i,
  input  logic                 lin_i,
  input  logic [NB*LANE_W-1:0] wdata_i,
  output logic [NB*LANE_W-1:0] rdata_o,
  output logic                 drive_o
);
  localparam int unsigned DW = NB * LANE_W;
  localparam int unsigned HW = AW - CW;

  logic          ld, adv, desel, active, wr_seen;
  sbs_op_e       op;
  logic [NB-1:0] be;
  logic [HW-1:0] hi_q;
  logic [CW-1:0] low;
  logic [AW-1:0] acc_addr;
  logic [DW-1:0] ram_q, rdata_q;
  logic          rd_v1_q, drive_q;

  sbs_access_ctrl #(.NB(NB)) i_ctrl (
    .clk(clk), .rst(rst),
    .adsp_n_i(adsp_n_i), .adsc_n_i(adsc_n_i), .adv_n_i(adv_n_i),
    .ce1_n_i(ce1_n_i), .ce2_i(ce2_i), .ce3_n_i(ce3_n_i),
    .gw_n_i(gw_n_i), .bwe_n_i(bwe_n_i), .bw_n_i(bw_n_i),
    .ld_o(ld), .adv_o(adv), .desel_o(desel), .op_o(op), .be_o(be),
    .active_o(active), .wr_seen_o(wr_seen)
  );

  sbs_burst_seq #(.CW(CW)) i_burst (
    .clk(clk), .rst(rst), .ld_i(ld), .adv_i(adv), .lin_i(lin_i),
    .base_i(addr_i[CW-1:0]), .low_o(low)
  );

  always_ff @(posedge clk) begin
    if (rst) hi_q <= '0;
    else if (ld) hi_q <= addr_i[AW-1:CW];
  end

  assign acc_addr = {ld ? addr_i[AW-1:CW] : hi_q, low};

  sbs_lane_ram #(.AW(AW), .NB(NB)) i_ram (
    .clk(clk), .rst(rst), .addr_i(acc_addr),
    .rd_en_i(op == OP_RD),
    .we_i((op == OP_WR) ? be : '0),
    .wd_i(wdata_i), .q_o(ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_v1_q <= 1'b0;
      drive_q <= 1'b0;
      rdata_q <= '0;
    end else begin
      rd_v1_q <= (op == OP_RD);
      drive_q <= rd_v1_q && !desel && (op != OP_WR);
      if (rd_v1_q) rdata_q <= ram_q;
    end
  end

  assign rdata_o = rdata_q;
  assign drive_o = drive_q && !oe_n_i && !wr_seen;

  assert_desel_off_R2: assert property (@(posedge clk) disable iff (rst)
    desel |=> !drive_q);
  assert_first_cycle_off_R7: assert property (@(posedge clk) disable iff (rst)
    (ld && !active) |=> !drive_q);
  assert_write_off_R8: assert property (@(posedge clk) disable iff (rst)
    (op == OP_WR) |=> !drive_q);
  assert_oe_gate_R8: assert property (@(posedge clk) disable iff (rst)
    oe_n_i |-> !drive_o);
  assert_latency_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(drive_q) |-> $past(rd_v1_q));
endmodule

// File: tb/test_sbs_sram_top.sv
module test_sbs_sram_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int NB = 4;
  localparam int DW = 32;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic          rst;
  logic [AW-1:0] addr;
  logic          adsp_n, adsc_n, adv_n, ce1_n, ce2, ce3_n, gw_n, bwe_n, oe_n, lin;
  logic [NB-1:0] bw_n;
  logic [DW-1:0] wdata, rdata;
  logic          drive;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] ref_mem [DEPTH];

  sbs_sram_top #(.AW(AW), .NB(NB), .CW(2)) i_sbs_sram_top (
    .clk(clk), .rst(rst), .addr_i(addr), .adsp_n_i(adsp_n), .adsc_n_i(adsc_n),
    .adv_n_i(adv_n), .ce1_n_i(ce1_n), .ce2_i(ce2), .ce3_n_i(ce3_n),
    .gw_n_i(gw_n), .bwe_n_i(bwe_n), .bw_n_i(bw_n), .oe_n_i(oe_n),
    .lin_i(lin), .wdata_i(wdata), .rdata_o(rdata), .drive_o(drive)
  );

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic defaults();
    adsp_n = 1'b1; adsc_n = 1'b1; adv_n = 1'b1;
    ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0;
    gw_n = 1'b1; bwe_n = 1'b1; bw_n = '1; oe_n = 1'b0; lin = 1'b1;
    wdata = '0; addr = '0;
  endtask

  function automatic logic [DW-1:0] pat(input int a, input int k);
    return 32'h11223344 ^ (32'(a) * 32'h01010101) ^ (32'(k) * 32'h10305070);
  endfunction

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] o, input logic [DW-1:0] n,
                                          input logic g, input logic b, input logic [3:0] s);
    logic [DW-1:0] r;
    r = o;
    for (int i = 0; i < 4; i++)
      if (!g || (!b && !s[i])) r[8*i +: 8] = n[8*i +: 8];
    return r;
  endfunction

  task automatic adsc_write(input int a, input logic [DW-1:0] d, input logic g,
                            input logic b, input logic [3:0] s);
    defaults();
    adsc_n = 1'b0; adv_n = 1'b0; addr = 4'(a); wdata = d;
    gw_n = g; bwe_n = b; bw_n = s;
    step();
    ref_mem[a] = merge(ref_mem[a], d, g, b, s);
    defaults();
  endtask

  task automatic read_check(input int a, input string tag);
    defaults();
    adsc_n = 1'b0; addr = 4'(a);
    step();
    defaults();
    step();
    chk({tag, " drive"}, 32'(drive), 32'd1);
    chk({tag, " data"}, rdata, ref_mem[a]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1;
    defaults();
    repeat (3) step();
    chk("R10 drive after reset", 32'(drive), 32'd0);
    rst = 1'b0;
    step();
    chk("R10 still deselected", 32'(drive), 32'd0);

    // R5: controller-strobe writes with advance held low (must be ignored)
    for (int a = 0; a < DEPTH; a++) adsc_write(a, pat(a, 0), 1'b0, 1'b1, 4'hF);

    // R2: strobe with ce2 inactive deselects
    defaults(); adsc_n = 1'b0; ce2 = 1'b0;
    step(); defaults();
    chk("R2 deselect by ce2", 32'(drive), 32'd0);

    // R1 / R7: pipelined read stream out of the deselected state
    for (int a = 0; a < DEPTH; a++) begin
      adsc_n = 1'b0; addr = 4'(a);
      step();
      if (a == 0) chk("R7 first cycle off", 32'(drive), 32'd0);
      else begin
        chk("R1 stream drive", 32'(drive), 32'd1);
        chk("R1 stream data", rdata, ref_mem[a-1]);
      end
    end
    defaults(); step();
    chk("R1 stream last", rdata, ref_mem[DEPTH-1]);

    // R6: every byte-select pattern
    for (int p = 0; p < 16; p++) begin
      adsc_write(5, pat(5, p + 1), 1'b1, 1'b0, 4'(p));
      read_check(5, "R6 byte lanes");
    end
    adsc_write(6, pat(6, 40), 1'b0, 1'b0, 4'hF);
    read_check(6, "R6 global overrides selects");

    // R4: processor-strobe write, first-edge controls ignored
    defaults();
    adsp_n = 1'b0; addr = 4'd9; gw_n = 1'b0; bwe_n = 1'b0; bw_n = 4'h0;
    adv_n = 1'b0; wdata = 32'hDEADBEEF;
    step();
    defaults();
    bwe_n = 1'b0; bw_n = 4'b1010; wdata = pat(9, 7);
    #1;
    chk("R8 write inputs gate drive", 32'(drive), 32'd0);
    step();
    ref_mem[9] = merge(ref_mem[9], pat(9, 7), 1'b1, 1'b0, 4'b1010);
    defaults(); #1;
    chk("R8 off after write edge", 32'(drive), 32'd0);
    read_check(9, "R4 second-edge write");

    // R3: processor strobe with ce1 high is ignored
    read_check(3, "R3 setup");
    ce1_n = 1'b1; adsp_n = 1'b0;
    step(); step();
    chk("R3 ignored drive", 32'(drive), 32'd1);
    chk("R3 ignored data", rdata, ref_mem[3]);
    adsc_n = 1'b0;
    step(); defaults();
    chk("R3 controller strobe deselects", 32'(drive), 32'd0);

    // R2: ce3 inactive deselects; later writes without strobe ignored
    read_check(2, "R2 setup");
    ce3_n = 1'b1; adsp_n = 1'b0;
    step(); defaults();
    chk("R2 deselect by ce3", 32'(drive), 32'd0);
    gw_n = 1'b0; wdata = '0; addr = 4'd2;
    step(); defaults();
    read_check(2, "R2 write while deselected ignored");

    // R8: output enable gating
    read_check(4, "R8 setup");
    oe_n = 1'b1; #1;
    chk("R8 oe high", 32'(drive), 32'd0);
    oe_n = 1'b0; #1;
    chk("R8 oe low", 32'(drive), 32'd1);

    // R9: bursts in both orders from every base
    for (int l = 0; l < 2; l++) begin
      for (int b = 0; b < 4; b++) begin
        int n;
        int cur_a;
        int prev_a;
        n = 0;
        prev_a = 0;
        for (int j = 0; j < 7; j++) begin
          defaults();
          if (j == 0) begin
            adsc_n = 1'b0; addr = 4'(8 + b); lin = 1'(l); n = 0;
          end else begin
            lin = 1'(1 - l);
            adv_n = (j == 4 || j == 6);
            if (!adv_n) n = (n + 1) % 4;
          end
          cur_a = 8 + ((l == 1) ? ((b + n) % 4) : (b ^ n));
          step();
          if (j > 0) chk(l == 1 ? "R9 linear burst" : "R9 interleaved burst",
                         rdata, ref_mem[prev_a]);
          prev_a = cur_a;
        end
        defaults(); step();
        chk("R9 burst tail", rdata, ref_mem[prev_a]);
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule